// File: doc/BRIEF.md
# Interrupt and Trap Controller

This block decides when a processor core has to leave its instruction stream and branch to a service routine. It watches two active-high hardware interrupt lines and one trap line. Each interrupt line has an enable bit that software can write. When it accepts an event, the block sends the core a one-cycle branch request with a fixed target address. It then holds an acknowledge output and a 4-bit code that names the event until the core reports that it executed the return-from-interrupt instruction.

Every source passes through a two-flop synchronizer and is edge-detected. A rising edge is stored as pending until that event is serviced. The trap has first priority, then the first interrupt, then the second. Nothing is accepted while a routine is active. A debug configuration register does two things: it moves the trap target to a debug address, and it can turn the trap pin around into an output. In output mode the pin reports breakpoint hits from the core to neighbouring processors, and the pin's input side is ignored.

Top module: `irq_trap_ctrl`

## Requirements
- R1: After reset, `branch_req`, `svc_ack`, `svc_code`, `trap_oe` and `trap_out` are 0, and both configuration registers read back as 0.
- R2: When enabled interrupt line k (k=0 or 1) rises, `branch_req` pulses high for exactly one cycle. The pulse comes at the fourth rising clock edge after the input first meets the first synchronizer stage. With the pulse, `branch_addr` is 0x0001 for line 0 and 0x0002 for line 1, and `svc_code` is 0x1 or 0x2 to match.
- R3: A write with `cfg_sel`=0 loads the enable register: bit 0 enables line 0, bit 1 enables line 1. `cfg_rdata` returns the selected register. A rising edge on a disabled line never causes a branch. The edge stays pending, and the line is serviced once its enable bit is set.
- R4: A rising edge on the trap input branches to 0x0046 with `svc_code` 0xF. When debug trap mode is set (`cfg_sel`=1, bit 0), it branches to 0x0003 instead.
- R5: `svc_ack` rises together with `branch_req` and stays high until `ret_exec` is sampled high. In the cycle after that, `svc_ack` is 0 and `svc_code` is 0x0.
- R6: No branch is requested while `svc_ack` is high. An event that arrives during service stays pending. Its `branch_req` comes one cycle after `svc_ack` falls.
- R7: When several events are pending at the same time, they are serviced in the order trap, line 0, line 1.
- R8: When the pin-output bit is set (`cfg_sel`=1, bit 1), `trap_oe` is 1. A `bkpt_hit` sampled high makes `trap_out` high for the next cycle only, and `trap_in` is ignored. When the bit is clear, `trap_out` stays 0.
- R9: An input held high gives exactly one service. No new branch follows the return until the input falls and rises again.
- R10: `ret_exec` while no routine is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 2 | Asynchronous active-high interrupt lines |
| trap_in | input | 1 | Input side of the trap pin |
| trap_out | output | 1 | Output side of the trap pin (breakpoint pulse) |
| trap_oe | output | 1 | Drive enable for the trap pin |
| bkpt_hit | input | 1 | Breakpoint hit reported by the core |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 enables, 1 debug control |
| cfg_wdata | input | 2 | Configuration write data |
| cfg_rdata | output | 2 | Selected register contents |
| ret_exec | input | 1 | Core executed the interrupt-return instruction |
| branch_req | output | 1 | One-cycle branch request to the core |
| branch_addr | output | 16 | Service vector address |
| svc_ack | output | 1 | Service routine active |
| svc_code | output | 4 | Code of the event being serviced |

## Verification
The bench measures the exact cycle of every branch from the moment the input changes. A design with one synchronizer stage too many or too few therefore fails on latency, not just on the target address. It fires all three sources in the same cycle and checks that they are serviced in order, so an arbiter with reversed priority, or one that loses an event it did not grant, is caught. It keeps a line high across a return, and it sends events during service, to expose level-triggered acceptance and nesting. It also toggles `trap_in` while the pin is in output mode, so a design that still samples the pin would start a stray service.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_IRQ     = 2;
    localparam int NUM_SRC     = NUM_IRQ + 1;
    localparam int ADDR_W      = 16;
    localparam int CODE_W      = 4;
    localparam int SYNC_STAGES = 2;
    localparam int CFG_W       = (NUM_IRQ > 2) ? NUM_IRQ : 2;

    localparam logic [ADDR_W-1:0] TRAP_ADDR_NORM = 16'h0046;
    localparam logic [ADDR_W-1:0] TRAP_ADDR_DBG  = 16'h0003;
    localparam logic [CODE_W-1:0] CODE_IDLE      = 4'h0;
    localparam logic [CODE_W-1:0] CODE_TRAP      = 4'hF;

    // Source index 0 is the trap, index i>0 is interrupt line i-1.
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               active;
        logic               req;
        logic [ADDR_W-1:0]  addr;
        logic [CODE_W-1:0]  code;
    } svc_state_t;

    typedef struct packed {
        logic [NUM_IRQ-1:0] en;
        logic               dbg_trap;
        logic               pin_out;
    } cfg_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], din};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a level produces a single-cycle event
    a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               sel,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   rdata,
    output logic [NUM_IRQ-1:0] irq_en,
    output logic               dbg_trap,
    output logic               pin_out_mode
);
    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (!sel) begin
                cfg_d.en = wdata[NUM_IRQ-1:0];
            end else begin
                cfg_d.dbg_trap = wdata[0];
                cfg_d.pin_out  = wdata[1];
            end
        end
        rdata = '0;
        if (!sel) rdata[NUM_IRQ-1:0] = cfg_q.en;
        else      rdata[1:0]         = {cfg_q.pin_out, cfg_q.dbg_trap};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign irq_en       = cfg_q.en;
    assign dbg_trap     = cfg_q.dbg_trap;
    assign pin_out_mode = cfg_q.pin_out;

    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(irq_en));
endmodule

// File: rtl/trap_pad_ctl.sv
module trap_pad_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic out_mode,
    input  logic bkpt_hit,
    output logic pin_out,
    output logic pin_oe,
    output logic trap_sense
);
    logic out_d, out_q;

    always_comb begin
        out_d      = out_mode & bkpt_hit;
        trap_sense = pin_in & ~out_mode;
        pin_oe     = out_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign pin_out = out_q;

    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out |-> $past(bkpt_hit));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               dbg_trap,
    input  logic               ret_exec,
    output logic               req,
    output logic [ADDR_W-1:0]  addr,
    output logic [CODE_W-1:0]  code,
    output logic               ack
);
    svc_state_t st_d, st_q;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] grant;
    logic               found;

    always_comb begin
        eligible = st_q.pend & {irq_en, 1'b1};
        grant    = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eligible[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end

        st_d     = st_q;
        st_d.req = 1'b0;
        if (st_q.active) begin
            grant = '0;
            if (ret_exec) begin
                st_d.active = 1'b0;
                st_d.code   = CODE_IDLE;
            end
        end else if (found) begin
            st_d.active = 1'b1;
            st_d.req    = 1'b1;
            if (grant[0]) begin
                st_d.addr = dbg_trap ? TRAP_ADDR_DBG : TRAP_ADDR_NORM;
                st_d.code = CODE_TRAP;
            end else begin
                for (int i = 1; i < NUM_SRC; i++) begin
                    if (grant[i]) begin
                        st_d.addr = ADDR_W'(i);
                        st_d.code = CODE_W'(i);
                    end
                end
            end
        end
        st_d.pend = (st_q.pend & ~grant) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req  = st_q.req;
    assign addr = st_q.addr;
    assign code = st_q.code;
    assign ack  = st_q.active;

    a_r6_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !$past(st_q.active));
    a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !ret_exec) |=> (st_q.active && !st_q.req));
    a_r5_ret_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && ret_exec) |=> (!st_q.active && st_q.code == CODE_IDLE));
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r2_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_q.code != CODE_TRAP) |-> (st_q.addr == ADDR_W'(st_q.code)));
    a_r10_idle_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !found) |=> !st_q.active);
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               trap_in,
    output logic               trap_out,
    output logic               trap_oe,
    input  logic               bkpt_hit,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               ret_exec,
    output logic               branch_req,
    output logic [ADDR_W-1:0]  branch_addr,
    output logic               svc_ack,
    output logic [CODE_W-1:0]  svc_code
);
    logic [NUM_IRQ-1:0] irq_en;
    logic               dbg_trap;
    logic               pin_out_mode;
    logic               trap_sense;
    logic [NUM_SRC-1:0] src_raw;
    logic [NUM_SRC-1:0] src_rise;

    irq_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .irq_en(irq_en),
        .dbg_trap(dbg_trap), .pin_out_mode(pin_out_mode)
    );

    trap_pad_ctl u_pad (
        .clk(clk), .rst_n(rst_n), .pin_in(trap_in), .out_mode(pin_out_mode),
        .bkpt_hit(bkpt_hit), .pin_out(trap_out), .pin_oe(trap_oe),
        .trap_sense(trap_sense)
    );

    assign src_raw = {irq_in, trap_sense};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(src_raw[g]), .rise(src_rise[g])
        );
    end

    irq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .rise(src_rise), .irq_en(irq_en),
        .dbg_trap(dbg_trap), .ret_exec(ret_exec), .req(branch_req),
        .addr(branch_addr), .code(svc_code), .ack(svc_ack)
    );

    a_r8_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_oe |=> !trap_out);
endmodule

// File: tb/sim_irq_trap_ctrl.sv
module sim_irq_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  irq_in = '0;
    logic        trap_in = 1'b0;
    logic        trap_out, trap_oe;
    logic        bkpt_hit = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic [1:0]  cfg_rdata;
    logic        ret_exec = 1'b0;
    logic        branch_req;
    logic [15:0] branch_addr;
    logic        svc_ack;
    logic [3:0]  svc_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_trap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trap_in(trap_in),
        .trap_out(trap_out), .trap_oe(trap_oe), .bkpt_hit(bkpt_hit),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ret_exec(ret_exec), .branch_req(branch_req),
        .branch_addr(branch_addr), .svc_ack(svc_ack), .svc_code(svc_code)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic sel, input logic [1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!branch_req && n < 30) begin
            tick();
            n++;
        end
    endtask

    task automatic do_ret();
        ret_exec = 1'b1;
        tick();
        ret_exec = 1'b0;
        chk(svc_ack == 1'b0, "R5 ack after ret", 32'(svc_ack), 0);
        chk(svc_code == 4'h0, "R5 code after ret", 32'(svc_code), 0);
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            tick();
            if (branch_req) seen++;
        end
        chk(seen == 0, req, 32'(seen), 0);
    endtask

    // one full service of an enabled source; line = mask on irq_in, or trap
    task automatic serve(input logic [1:0] mask, input bit trap,
                         input logic [15:0] exp_addr, input logic [3:0] exp_code,
                         input string req);
        int n;
        irq_in = irq_in | mask;
        if (trap) trap_in = 1'b1;
        wait_req(n);
        chk(n == 4, {req, " latency"}, 32'(n), 4);
        chk(branch_addr == exp_addr, {req, " addr"}, 32'(branch_addr), 32'(exp_addr));
        chk(svc_code == exp_code, {req, " code"}, 32'(svc_code), 32'(exp_code));
        chk(svc_ack == 1'b1, "R5 ack with req", 32'(svc_ack), 1);
        irq_in = irq_in & ~mask;
        trap_in = 1'b0;
        tick();
        chk(branch_req == 1'b0, "R2 single pulse", 32'(branch_req), 0);
        for (int i = 0; i < 4; i++) tick();
        chk(svc_ack == 1'b1, "R5 ack held", 32'(svc_ack), 1);
        chk(svc_code == exp_code, "R5 code held", 32'(svc_code), 32'(exp_code));
        do_ret();
        for (int i = 0; i < 3; i++) tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(branch_req == 0, "R1 branch_req", 32'(branch_req), 0);
        chk(svc_ack == 0, "R1 svc_ack", 32'(svc_ack), 0);
        chk(svc_code == 0, "R1 svc_code", 32'(svc_code), 0);
        chk(trap_oe == 0 && trap_out == 0, "R1 trap pin", 32'({trap_oe, trap_out}), 0);
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 0, "R1 enable reg", 32'(cfg_rdata), 0);
        cfg_sel = 1'b1; #1;
        chk(cfg_rdata == 0, "R1 debug reg", 32'(cfg_rdata), 0);

        // R3 enable register readback sweep
        for (int v = 0; v < 4; v++) begin
            write_cfg(1'b0, 2'(v));
            cfg_sel = 1'b0; #1;
            chk(cfg_rdata == 2'(v), "R3 readback", 32'(cfg_rdata), 32'(v));
        end

        // R2 each line
        serve(2'b01, 1'b0, 16'h0001, 4'h1, "R2 line0");
        serve(2'b10, 1'b0, 16'h0002, 4'h2, "R2 line1");

        // R9 held level
        irq_in = 2'b01;
        wait_req(n);
        chk(n == 4, "R9 first service", 32'(n), 4);
        tick();
        do_ret();
        quiet(10, "R9 no repeat while held");
        irq_in = 2'b00;
        tick(); tick();

        // R10 return while idle
        ret_exec = 1'b1; tick(); ret_exec = 1'b0; tick();
        chk(svc_ack == 0 && branch_req == 0, "R10 idle ret", 32'({svc_ack, branch_req}), 0);
        serve(2'b10, 1'b0, 16'h0002, 4'h2, "R10 after idle ret");

        // R3 disabled line stays pending
        write_cfg(1'b0, 2'b10);
        irq_in = 2'b01; tick(); tick(); irq_in = 2'b00;
        quiet(10, "R3 disabled no branch");
        write_cfg(1'b0, 2'b11);
        wait_req(n);
        chk(n < 30 && branch_addr == 16'h0001, "R3 pending served on enable",
            32'(branch_addr), 1);
        tick(); do_ret(); tick();

        // R4 trap normal and debug target
        serve(2'b00, 1'b1, 16'h0046, 4'hF, "R4 trap normal");
        write_cfg(1'b1, 2'b01);
        serve(2'b00, 1'b1, 16'h0003, 4'hF, "R4 trap debug");
        write_cfg(1'b1, 2'b00);

        // R6 no nesting
        irq_in = 2'b01;
        wait_req(n);
        irq_in = 2'b00;
        tick();
        irq_in = 2'b10; tick(); tick(); irq_in = 2'b00;
        quiet(8, "R6 held off during service");
        ret_exec = 1'b1; tick(); ret_exec = 1'b0;
        chk(svc_ack == 0 && branch_req == 0, "R6 gap cycle", 32'({svc_ack, branch_req}), 0);
        tick();
        chk(branch_req == 1 && svc_code == 4'h2, "R6 pending after ret",
            32'({branch_req, svc_code}), 32'h12);
        tick(); do_ret(); tick();

        // R7 priority: all three together
        irq_in = 2'b11; trap_in = 1'b1;
        wait_req(n);
        irq_in = 2'b00; trap_in = 1'b0;
        chk(svc_code == 4'hF, "R7 trap first", 32'(svc_code), 32'hF);
        tick(); do_ret();
        tick();
        chk(branch_req == 1 && svc_code == 4'h1, "R7 line0 second",
            32'({branch_req, svc_code}), 32'h11);
        tick(); do_ret();
        tick();
        chk(branch_req == 1 && svc_code == 4'h2, "R7 line1 third",
            32'({branch_req, svc_code}), 32'h12);
        tick(); do_ret();
        quiet(5, "R7 nothing left");

        // R8 pin output mode
        write_cfg(1'b1, 2'b10);
        chk(trap_oe == 1, "R8 oe set", 32'(trap_oe), 1);
        bkpt_hit = 1'b1; tick(); bkpt_hit = 1'b0;
        chk(trap_out == 1, "R8 pulse high", 32'(trap_out), 1);
        tick();
        chk(trap_out == 0, "R8 pulse one cycle", 32'(trap_out), 0);
        trap_in = 1'b1; tick(); tick(); trap_in = 1'b0;
        quiet(10, "R8 pin input ignored");
        write_cfg(1'b1, 2'b00);
        chk(trap_oe == 0, "R8 oe clear", 32'(trap_oe), 0);
        bkpt_hit = 1'b1; tick(); bkpt_hit = 1'b0;
        chk(trap_out == 0, "R8 no pulse in input mode", 32'(trap_out), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule